// File: doc/BRIEF.md
# Cascadable Binary Rate Multiplier

This block produces a pulse train whose average rate is a programmable fraction of the clock rate. A six-bit counter cycles through 64 states. Each bit of a six-bit select word is paired with its own decode of the counter state. Bit 5 matches every second state, bit 4 every fourth state, and so on down to bit 0, which matches once per cycle. Over one 64-clock cycle the active-low output `z_n` is therefore low in exactly m periods, where m is the select word read as an unsigned number.

Each output pulse is a one-clock-wide synchronous strobe. The block never gates the clock. The output `y` is normally the complement of `z_n`. A low level on `y_inj_n` forces `y` high, which lets an upstream stage inject its own pulses into this stage's output.

Two instances form a 12-bit multiplier as follows:
- The low-order stage's terminal count drives both the count enable and the Z enable of the high-order stage.
- The low-order stage's `z_n` drives the high-order stage's `y_inj_n`.
- The merged pulse train is taken from the high-order stage's `y`.

Top module: `brm_core`

## Requirements
- R1: The internal counter advances by one, wrapping from 63 to 0, on each rising clock edge while `ce_n` is low and `rst_n` is high. While `ce_n` is high it holds its value.
- R2: While `rst_n` is sampled low the counter is cleared and held at 0. During that time `z_n` still goes low whenever `z_en_n` is low and `sel[5]` is 1.
- R3: Let t be the number of consecutive 1 bits in the count, starting from bit 0. For t from 0 to 5, the period is selected by `sel[5-t]`. With `z_en_n` low, `z_n` is low in that period exactly when that select bit is 1.
- R4: Over any 64 consecutive counting clocks with `z_en_n` low, `z_n` is low in exactly m periods, where m = 32·sel[5] + 16·sel[4] + 8·sel[3] + 4·sel[2] + 2·sel[1] + sel[0].
- R5: `z_n` is high whenever the count is 63, whatever the value of `sel`.
- R6: `tc_n` is low exactly when the count is 63 and `ce_n` is low.
- R7: While `z_en_n` is high, `z_n` stays high.
- R8: `y` equals the inverse of `z_n` while `y_inj_n` is high. While `y_inj_n` is low, `y` is high.
- R9: In the two-stage cascade, the high-order stage's `y` is high in exactly 64·m1 + m2 periods of every 4096 clocks. Here m1 is the low-order select value and m2 the high-order one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; clears and holds the counter |
| ce_n | input | 1 | Active-low count enable |
| z_en_n | input | 1 | Active-low enable for the pulse output `z_n` |
| y_inj_n | input | 1 | Active-low pulse merge; low forces `y` high |
| sel | input | 6 | Rate select word m |
| z_n | output | 1 | Active-low rate pulse, one clock wide |
| y | output | 1 | Complement pulse output with merge |
| tc_n | output | 1 | Active-low terminal count for cascading |

## Verification
The pulse outputs are a direct combinational decode of the counter. A wrong count therefore shows up in the same clock period as a pulse in the wrong slot, or as a missing or extra pulse. A stuck or skipping counter moves `tc_n` away from the 64th counting clock, so it is seen within one cycle of 64 clocks. Comparing every period for all 64 select values finds a wrong decode term within the first cycle that uses that bit. The cascade run shows a wrong enable or merge connection as a wrong pulse total over 4096 clocks.

// File: rtl/brm_pkg.sv
// Package: shared width default and the status record passed from the
// counter to the output stage of the rate multiplier.
// Assumes: all users take their counter width from a module parameter.
package brm_pkg;

    // Default counter width; 6 bits gives a 64-state cycle.
    localparam int unsigned BRM_DEF_W = 6;

    // Counter status seen by the output stage.
    typedef struct packed {
        logic at_max;   // counter holds the all-ones state
        logic counting; // counter is enabled this period
    } brm_cnt_stat_t;

endpackage

// File: rtl/brm_counter.sv
// Module: brm_counter
// Binary up-counter of W bits that steps once per clock while the active-low
// enable is low and wraps to zero after the all-ones state.
// Assumes: rst_n is synchronous and active-low; all bits change on one edge.
module brm_counter
    import brm_pkg::*;
#(
    parameter int unsigned W = BRM_DEF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    output logic [W-1:0]  cnt,
    output brm_cnt_stat_t stat
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    // Purpose: clear on reset, step by one when counting is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!ce_n) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    // Purpose: derive the status flags consumed by the output stage.
    always_comb begin
        stat.at_max   = (cnt == CNT_MAX);
        stat.counting = ~ce_n;
    end

endmodule

// File: rtl/brm_decode.sv
// Module: brm_decode
// Produces one match term per select bit. Select bit j (weight 2^j) matches
// when the lowest W-1-j count bits are all ones and count bit W-1-j is zero.
// Assumes: the terms are mutually exclusive and none is true at all ones.
module brm_decode #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] cnt,
    output logic [W-1:0] term
);

    // One decode per select bit; the structure repeats with a growing mask.
    for (genvar j = 0; j < W; j++) begin : g_term
        localparam int unsigned K = W - 1 - j;
        if (K == 0) begin : g_lsb
            // Purpose: the highest-weight bit matches whenever count bit 0 is 0.
            always_comb term[j] = ~cnt[0];
        end else begin : g_mid
            // Purpose: the lower K bits must be all ones, bit K must be zero.
            always_comb term[j] = (&cnt[K-1:0]) & ~cnt[K];
        end
    end

endmodule

// File: rtl/brm_output.sv
// Module: brm_output
// Combines the match terms with the select word and the enables to form the
// active-low rate pulse, its merged complement and the terminal count.
// Assumes: term holds at most one true bit per period.
module brm_output
    import brm_pkg::*;
#(
    parameter int unsigned W = BRM_DEF_W
) (
    input  logic [W-1:0]  term,
    input  logic [W-1:0]  sel,
    input  logic          z_en_n,
    input  logic          y_inj_n,
    input  brm_cnt_stat_t stat,
    output logic          z_n,
    output logic          y,
    output logic          tc_n
);

    logic hit;

    // Purpose: a period is selected when its matching term has its bit set.
    always_comb hit = |(term & sel);

    // Purpose: gate the pulse with its enable and drive it active-low.
    always_comb z_n = ~(hit & ~z_en_n);

    // Purpose: complement output, forced high by an injected upstream pulse.
    always_comb y = ~(z_n & y_inj_n);

    // Purpose: flag the last state of the cycle while counting is enabled.
    always_comb tc_n = ~(stat.at_max & stat.counting);

endmodule

// File: rtl/brm_core.sv
// Module: brm_core
// Binary rate multiplier: over each 2^W-clock cycle it drives z_n low in m
// periods, m being the select word. The outputs are synchronous strobes.
// Assumes: one clock domain; rst_n is synchronous and active-low.
module brm_core
    import brm_pkg::*;
#(
    parameter int unsigned W = BRM_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n,
    input  logic         z_en_n,
    input  logic         y_inj_n,
    input  logic [W-1:0] sel,
    output logic         z_n,
    output logic         y,
    output logic         tc_n
);

    logic [W-1:0]  cnt;
    logic [W-1:0]  term;
    brm_cnt_stat_t stat;

    brm_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .cnt   (cnt),
        .stat  (stat)
    );

    brm_decode #(.W(W)) u_dec (
        .cnt  (cnt),
        .term (term)
    );

    brm_output #(.W(W)) u_out (
        .term    (term),
        .sel     (sel),
        .z_en_n  (z_en_n),
        .y_inj_n (y_inj_n),
        .stat    (stat),
        .z_n     (z_n),
        .y       (y),
        .tc_n    (tc_n)
    );

endmodule

// File: rtl/brm_core_chk.sv
// Module: brm_core_chk
// Property checker attached to every brm_core instance. It watches the ports
// and the counter and decode signals between the submodules.
// Assumes: rst_n is synchronous and active-low.
module brm_core_chk #(
    parameter int unsigned W = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ce_n,
    input logic         z_en_n,
    input logic         y_inj_n,
    input logic         z_n,
    input logic         y,
    input logic         tc_n,
    input logic [W-1:0] cnt,
    input logic [W-1:0] term
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |=> cnt == $past(cnt) + W'(1)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(cnt)); // R1
    AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(term)); // R3
    AST_QUIET_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt) |-> z_n); // R5
    AST_TC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_n |-> (!ce_n && (&cnt))); // R6
    AST_Z_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        z_en_n |-> z_n); // R7
    AST_Y_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (y_inj_n |-> (y == !z_n)) and (!y_inj_n |-> y)); // R8

endmodule

bind brm_core brm_core_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .z_en_n  (z_en_n),
    .y_inj_n (y_inj_n),
    .z_n     (z_n),
    .y       (y),
    .tc_n    (tc_n),
    .cnt     (cnt),
    .term    (term)
);

// File: tb/test_brm_core.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs of each period into
// a queue, and a monitor pops and compares them at the falling clock edge.
module test_brm_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       z_en_n = 1'b0;
    logic       y_inj_n = 1'b1;
    logic [5:0] sel = '0;
    logic       z_n, y, tc_n;

    // Cascade pair
    logic [5:0] m_lo = '0, m_hi = '0;
    logic       lo_z_n, lo_y, lo_tc_n, hi_z_n, hi_y, hi_tc_n;

    typedef struct {
        logic  z_n;
        logic  y;
        logic  tc_n;
        string tag;
    } exp_t;

    exp_t q[$];
    int   nchk = 0, nfail = 0;
    int   pulses = 0, cpulses = 0;
    int   mcnt = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    brm_core i_brm_core (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .z_en_n(z_en_n),
        .y_inj_n(y_inj_n), .sel(sel), .z_n(z_n), .y(y), .tc_n(tc_n)
    );

    brm_core i_casc_lo (
        .clk(clk), .rst_n(rst_n), .ce_n(1'b0), .z_en_n(1'b0),
        .y_inj_n(1'b1), .sel(m_lo), .z_n(lo_z_n), .y(lo_y), .tc_n(lo_tc_n)
    );

    brm_core i_casc_hi (
        .clk(clk), .rst_n(rst_n), .ce_n(lo_tc_n), .z_en_n(lo_tc_n),
        .y_inj_n(lo_z_n), .sel(m_hi), .z_n(hi_z_n), .y(hi_y), .tc_n(hi_tc_n)
    );

    // Reference for R3/R5: trailing-ones count picks the select bit.
    function automatic logic ref_z(int c, logic [5:0] s, logic en_n);
        int t = 0;
        if (en_n) return 1'b1;
        while (t < 6 && ((c >> t) & 1) == 1) t++;
        if (t >= 6) return 1'b1;
        return ~s[5-t];
    endfunction

    task automatic check(string req, int act, int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Driver: push expected values for this period, then advance one clock.
    task automatic cyc(string tag);
        exp_t e;
        e.z_n  = ref_z(mcnt, sel, z_en_n);
        e.y    = y_inj_n ? ~e.z_n : 1'b1;
        e.tc_n = (mcnt == 63 && !ce_n) ? 1'b0 : 1'b1;
        e.tag  = (mcnt == 63 && !z_en_n) ? "R5" : tag;
        q.push_back(e);
        @(posedge clk);
        if (!rst_n) mcnt = 0;
        else if (!ce_n) mcnt = (mcnt + 1) % 64;
        #1;
    endtask

    // Monitor: compare at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, int'(z_n), int'(e.z_n));
            check("R8", int'(y), int'(e.y));
            check("R6", int'(tc_n), int'(e.tc_n));
            if (!z_n) pulses++;
        end
        if (hi_y) cpulses++;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        // Reset state
        sel = '0; z_en_n = 1'b0;
        cyc("R2");
        // R2: pulse still appears in reset when sel[5] set
        sel = 6'b100000;
        for (int i = 0; i < 3; i++) cyc("R2");
        // R3/R4: every select value over a full cycle
        for (int m = 0; m < 64; m++) begin
            sel = 6'(m); rst_n = 1'b0; ce_n = 1'b1; y_inj_n = 1'b1;
            cyc("R2");
            rst_n = 1'b1; ce_n = 1'b0; pulses = 0;
            for (int i = 0; i < 64; i++) begin
                y_inj_n = (i % 3 != 0);
                cyc("R3");
            end
            check("R4", pulses, m);
        end
        // R1: hold while count enable is high
        sel = 6'b010101; y_inj_n = 1'b1; ce_n = 1'b0;
        for (int i = 0; i < 5; i++) cyc("R1");
        ce_n = 1'b1;
        for (int i = 0; i < 6; i++) cyc("R1");
        ce_n = 1'b0;
        for (int i = 0; i < 70; i++) cyc("R1");
        // R7: Z enable high suppresses pulses
        sel = 6'h3f; z_en_n = 1'b1; pulses = 0;
        for (int i = 0; i < 64; i++) cyc("R7");
        check("R7", pulses, 0);
        z_en_n = 1'b0;
        // R8: injection forces y high
        y_inj_n = 1'b0;
        for (int i = 0; i < 8; i++) cyc("R8");
        y_inj_n = 1'b1;
        // R9: cascaded pair over 4096 clocks
        for (int k = 0; k < 2; k++) begin
            m_lo = (k == 0) ? 6'd5 : 6'd63;
            m_hi = (k == 0) ? 6'd37 : 6'd63;
            rst_n = 1'b0;
            cyc("R2");
            rst_n = 1'b1; cpulses = 0;
            for (int i = 0; i < 4096; i++) cyc("R3");
            check("R9", cpulses, 64 * int'(m_lo) + int'(m_hi));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule